// File: doc/BRIEF.md
# Framebuffer Word to Pixel Unpacker

This block sits between a framebuffer fetch path and a display pipeline. It takes 32-bit words read from video memory and breaks each one into pixels, producing one pixel per output beat. The depth code, two ordering controls, a red/blue swap control and a 2-bit external format selector decide how a word is cut up and how each pixel is decoded. Depths of 1, 2, 4 and 8 bits per pixel produce a palette index. The 12-bit, 16-bit and 32-bit formats produce a 24-bit colour made of three 8-bit channels.

Both the word input and the pixel output use a valid/ready handshake. A new word is taken only once every pixel of the word being held has left the block. The controls are captured together with each word, so they may change at any time without disturbing a word that is already being unpacked. Separately, and purely from the current controls, the block gives the number of source bytes that one display line of a given column count occupies in memory. A parameter selects the extended variant, which decodes two more depth codes natively and ignores the external selector.

Top module: `fb_word_unpacker`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, no word is held: `pix_valid` is 0 and `word_ready` is 1.
- R2: A word is taken on an edge where `word_valid` and `word_ready` are both 1. `word_ready` then stays 0 until the edge that accepts the last of its 32/bpp pixels. The pixel and `pix_valid` hold steady while `pix_ready` is 0.
- R3: Depth codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bpp. The pixel appears zero-extended on `pix_index`, with `pix_is_index` = 1 and `pix_rgb` = 0.
- R4: With both ordering controls at 0, pixel i of a word with pixel width w comes from word bits [i*w +: w].
- R5: When `order_big_bytes` is 1, the setting of `order_big_pixels` has no effect and pixel i comes from bits [32-(i+1)*w +: w].
- R6: When only `order_big_pixels` is 1, pixel i comes from bit offset (i*w) XOR (8-w) for w below 8, and from bits [i*w +: w] for w of 8 or more.
- R7: In 5551 format the first channel is bits [4:0], the second [9:5] and the third [14:10], and bit 15 is ignored. `pix_rgb` is {red, green, blue} with red in [23:16]. Each channel is widened to 8 bits by a left shift with zero fill, and `pix_is_index` = 0 with `pix_index` = 0.
- R8: Depth code 5 (32 bpp) takes the first channel from bits [7:0], the second from [15:8] and the third from [23:16], and bits [31:24] are ignored.
- R9: With `swap_rb` at 0, red is the first channel and blue the third. With `swap_rb` at 1 the two trade places. Green is always the middle channel.
- R10: In the default variant, depth code 4 is decoded under control of `fmt_sel`. A value of 1 gives 5551 and follows `swap_rb`. A value of 3 gives 565 with the swap forced on. Values 0 and 2 give 565 and follow `swap_rb`. In 565, the first channel is bits [4:0], the second [10:5] and the third [15:11].
- R11: In the default variant, depth codes 6 and 7 behave as code 4. In the extended variant (EXTENDED=1), `fmt_sel` is ignored: code 4 is always 5551, code 6 is 565 and code 7 is 12-bit 444 in 16-bit slots, with channels at [3:0], [7:4] and [11:8]. All three follow `swap_rb`.
- R12: The depth, ordering, swap and format controls are captured when a word is accepted. Changing them while that word is held does not alter its remaining pixels.
- R13: `line_bytes` equals `line_cols` shifted right by 3, 2 or 1 for codes 0, 1 and 2. It equals `line_cols` for code 3, `line_cols`*4 for code 5 and `line_cols`*2 for codes 4, 6 and 7. It is combinational from the current depth code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| depth_code | input | 3 | Pixel depth and format code |
| order_big_bytes | input | 1 | Most-significant-first byte and pixel order |
| order_big_pixels | input | 1 | Most-significant-first pixels inside little-endian bytes |
| swap_rb | input | 1 | Swap the red and blue channel positions |
| fmt_sel | input | 2 | External selector for the 16-bit format |
| word_valid | input | 1 | Input word is valid |
| word_data | input | 32 | Framebuffer word |
| word_ready | output | 1 | Block can take a word |
| pix_valid | output | 1 | Pixel output is valid |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index, zero-extended |
| pix_rgb | output | 24 | Colour {R,G,B}, 8 bits each |
| line_cols | input | 12 | Column count for the line-size query |
| line_bytes | output | 14 | Source bytes per line |

## Verification
On every cycle the assertions check the handshake: an accepted word produces a pixel on the next cycle, a stalled pixel does not change, and accepting the last pixel frees the input. They also check that the index and colour outputs are never active together, and that 8-bpp line size equals the column count. Bit placement under each ordering mode, channel extraction and swapping, the decode chosen by each `fmt_sel` value and variant, and the capture of controls at word acceptance can only be shown by the bench. Its scenarios compare every pixel against a model built from the requirements.

// File: rtl/fbu_pkg.sv
// Shared types for the framebuffer word unpacker.
// Assumes nothing beyond the enum encodings below.
package fbu_pkg;

    // Decode family of a pixel
    typedef enum logic [2:0] {
        FMT_INDEX = 3'd0,
        FMT_5551  = 3'd1,
        FMT_565   = 3'd2,
        FMT_444   = 3'd3,
        FMT_888   = 3'd4
    } pix_fmt_e;

    // Resolved pixel format: decode family, log2 of the slot width, channel swap
    typedef struct packed {
        pix_fmt_e   fmt;
        logic [2:0] lg;
        logic       swap;
    } pix_cfg_t;

endpackage

// File: rtl/fbu_format_resolve.sv
// Turns the depth code, the swap control and the external 16-bit selector
// into a resolved pixel format. Purely combinational.
// Assumes EXTENDED picks the variant that decodes codes 6 and 7 natively.
module fbu_format_resolve
    import fbu_pkg::*;
#(
    parameter bit EXTENDED = 1'b0
) (
    input  logic [2:0] depth_code,
    input  logic [1:0] fmt_sel,
    input  logic       swap_rb,
    output pix_cfg_t   cfg
);

    // Decode for the 16-bit code under control of the external selector
    pix_cfg_t mux16;
    always_comb begin
        mux16.lg = 3'd4;
        case (fmt_sel)
            2'd1:    begin mux16.fmt = FMT_5551; mux16.swap = swap_rb; end
            2'd3:    begin mux16.fmt = FMT_565;  mux16.swap = 1'b1;    end
            default: begin mux16.fmt = FMT_565;  mux16.swap = swap_rb; end
        endcase
    end

    // Pick the final format from the depth code and the variant
    always_comb begin
        cfg.swap = swap_rb;
        cfg.lg   = 3'd4;
        cfg.fmt  = FMT_5551;
        case (depth_code)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                cfg.fmt  = FMT_INDEX;
                cfg.lg   = depth_code;
                cfg.swap = 1'b0;
            end
            3'd5: begin
                cfg.fmt = FMT_888;
                cfg.lg  = 3'd5;
            end
            3'd4: begin
                if (EXTENDED) cfg.fmt = FMT_5551;
                else          cfg = mux16;
            end
            default: begin
                if (EXTENDED) cfg.fmt = (depth_code == 3'd6) ? FMT_565 : FMT_444;
                else          cfg = mux16;
            end
        endcase
    end

endmodule

// File: rtl/fbu_line_bytes.sv
// Computes how many source bytes one display line occupies for a column
// count at the current depth. Assumes codes 4, 6 and 7 all use 16-bit slots.
module fbu_line_bytes #(
    parameter int COL_W = 12,
    localparam int OUT_W = COL_W + 2
) (
    input  logic [2:0]       depth_code,
    input  logic [COL_W-1:0] line_cols,
    output logic [OUT_W-1:0] line_bytes
);

    logic [OUT_W-1:0] cols_wide;
    assign cols_wide = {2'b00, line_cols};

    // Scale the column count by the pixel width in bytes
    always_comb begin
        case (depth_code)
            3'd0:    line_bytes = cols_wide >> 3;
            3'd1:    line_bytes = cols_wide >> 2;
            3'd2:    line_bytes = cols_wide >> 1;
            3'd3:    line_bytes = cols_wide;
            3'd5:    line_bytes = cols_wide << 2;
            default: line_bytes = cols_wide << 1;
        endcase
    end

    // Check the 8-bpp line size against the column count
    always_comb begin
        // R13
        byte_depth_chk: assert (depth_code != 3'd3 || line_bytes == OUT_W'(line_cols));
    end

endmodule

// File: rtl/fbu_pixel_seq.sv
// Holds one framebuffer word with the controls captured at acceptance.
// Steps through its pixels and presents the raw bit field of the current
// pixel at bit 0. Assumes WORD_W is a power of two, at least 32.
module fbu_pixel_seq
    import fbu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  pix_cfg_t          cfg_in,
    input  logic              big_bytes_in,
    input  logic              big_pixels_in,
    output logic              pix_valid,
    input  logic              pix_ready,
    output pix_cfg_t          cfg_held,
    output logic [WORD_W-1:0] field
);

    localparam int IDX_W = $clog2(WORD_W);

    logic              full_q;
    logic [WORD_W-1:0] word_q;
    pix_cfg_t          cfg_q;
    logic              bb_q;
    logic              bp_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  mask;
    logic [IDX_W-1:0]  offset;
    int                slot_w;

    assign word_ready = !full_q;
    assign pix_valid  = full_q;
    assign cfg_held   = cfg_q;

    // Capture a word with its controls, then advance one pixel per accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            word_q <= '0;
            cfg_q  <= pix_cfg_t'('0);
            bb_q   <= 1'b0;
            bp_q   <= 1'b0;
            idx_q  <= '0;
        end else if (word_valid && word_ready) begin
            full_q <= 1'b1;
            word_q <= word_data;
            cfg_q  <= cfg_in;
            bb_q   <= big_bytes_in;
            bp_q   <= big_pixels_in;
            idx_q  <= '0;
        end else if (full_q && pix_ready) begin
            if (idx_q == last_idx) full_q <= 1'b0;
            else                   idx_q  <= idx_q + 1'b1;
        end
    end

    // Locate the current pixel inside the held word under the captured ordering
    always_comb begin
        slot_w   = 1 << cfg_q.lg;
        last_idx = IDX_W'((WORD_W >> cfg_q.lg) - 1);
        if (bb_q)                       mask = IDX_W'(WORD_W - slot_w);
        else if (bp_q && cfg_q.lg < 3)  mask = IDX_W'(8 - slot_w);
        else                            mask = '0;
        offset = IDX_W'(idx_q << cfg_q.lg) ^ mask;
        field  = word_q >> offset;
    end

    // R2
    accept_to_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready |=> pix_valid && !word_ready);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(field) && $stable(cfg_held));

    // R2
    last_frees_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && idx_q == last_idx |=> word_ready);

endmodule

// File: rtl/fbu_color_expand.sv
// Decodes the raw field of one pixel into either a palette index or an
// 8-bit-per-channel colour. Assumes the field is at least 32 bits wide.
module fbu_color_expand
    import fbu_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  pix_cfg_t          cfg,
    input  logic [WORD_W-1:0] field,
    output logic              is_index,
    output logic [7:0]        index,
    output logic [23:0]       rgb
);

    logic [7:0] ch_lo;
    logic [7:0] ch_mid;
    logic [7:0] ch_hi;
    logic [7:0] idx_mask;

    // Pull out the three channels, widened by zero fill on the right
    always_comb begin
        ch_lo  = '0;
        ch_mid = '0;
        ch_hi  = '0;
        case (cfg.fmt)
            FMT_5551: begin
                ch_lo  = {field[4:0],   3'b000};
                ch_mid = {field[9:5],   3'b000};
                ch_hi  = {field[14:10], 3'b000};
            end
            FMT_565: begin
                ch_lo  = {field[4:0],   3'b000};
                ch_mid = {field[10:5],  2'b00};
                ch_hi  = {field[15:11], 3'b000};
            end
            FMT_444: begin
                ch_lo  = {field[3:0],  4'h0};
                ch_mid = {field[7:4],  4'h0};
                ch_hi  = {field[11:8], 4'h0};
            end
            FMT_888: begin
                ch_lo  = field[7:0];
                ch_mid = field[15:8];
                ch_hi  = field[23:16];
            end
            default: ;
        endcase
    end

    // Drive either the index or the swapped-as-needed colour
    always_comb begin
        idx_mask = 8'((1 << (1 << cfg.lg)) - 1);
        is_index = (cfg.fmt == FMT_INDEX);
        if (is_index) begin
            index = field[7:0] & idx_mask;
            rgb   = '0;
        end else begin
            index = '0;
            rgb   = cfg.swap ? {ch_hi, ch_mid, ch_lo} : {ch_lo, ch_mid, ch_hi};
        end
    end

    // Check that the two output kinds never overlap
    always_comb begin
        // R3
        index_rgb_clear_chk: assert (!is_index || rgb == 24'h0);
        // R7
        direct_index_clear_chk: assert (is_index || index == 8'h00);
    end

endmodule

// File: rtl/fb_word_unpacker.sv
// Top of the framebuffer word unpacker: resolves the format, sequences the
// pixels of each held word, decodes them and reports the line size.
// Assumes 32-bit words (WORD_W) and controls sampled at word acceptance.
module fb_word_unpacker
    import fbu_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int COL_W    = 12,
    parameter bit EXTENDED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        depth_code,
    input  logic              order_big_bytes,
    input  logic              order_big_pixels,
    input  logic              swap_rb,
    input  logic [1:0]        fmt_sel,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic              pix_is_index,
    output logic [7:0]        pix_index,
    output logic [23:0]       pix_rgb,
    input  logic [COL_W-1:0]  line_cols,
    output logic [COL_W+1:0]  line_bytes
);

    pix_cfg_t          cfg_now;
    pix_cfg_t          cfg_held;
    logic [WORD_W-1:0] field;

    fbu_format_resolve #(.EXTENDED(EXTENDED)) u_resolve (
        .depth_code (depth_code),
        .fmt_sel    (fmt_sel),
        .swap_rb    (swap_rb),
        .cfg        (cfg_now)
    );

    fbu_pixel_seq #(.WORD_W(WORD_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .word_ready    (word_ready),
        .cfg_in        (cfg_now),
        .big_bytes_in  (order_big_bytes),
        .big_pixels_in (order_big_pixels),
        .pix_valid     (pix_valid),
        .pix_ready     (pix_ready),
        .cfg_held      (cfg_held),
        .field         (field)
    );

    fbu_color_expand #(.WORD_W(WORD_W)) u_expand (
        .cfg      (cfg_held),
        .field    (field),
        .is_index (pix_is_index),
        .index    (pix_index),
        .rgb      (pix_rgb)
    );

    fbu_line_bytes #(.COL_W(COL_W)) u_lines (
        .depth_code (depth_code),
        .line_cols  (line_cols),
        .line_bytes (line_bytes)
    );

endmodule

// File: tb/fb_word_unpacker_test.sv
`timescale 1ns/1ps
module fb_word_unpacker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  depth = 3'd0;
    logic        bbyte = 1'b0;
    logic        bpix = 1'b0;
    logic        swp = 1'b0;
    logic [1:0]  fsel = 2'd0;
    logic        wvalid = 1'b0;
    logic [31:0] wdata = '0;
    logic        pready = 1'b1;
    logic [11:0] cols = '0;

    logic        wready, pvalid, pidx_f;
    logic [7:0]  pidx;
    logic [23:0] prgb;
    logic [13:0] lbytes;
    logic        x_wready, x_pvalid, x_pidx_f;
    logic [7:0]  x_pidx;
    logic [23:0] x_prgb;
    logic [13:0] x_lbytes;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fb_word_unpacker uut (
        .clk(clk), .rst_n(rst_n), .depth_code(depth), .order_big_bytes(bbyte),
        .order_big_pixels(bpix), .swap_rb(swp), .fmt_sel(fsel),
        .word_valid(wvalid), .word_data(wdata), .word_ready(wready),
        .pix_valid(pvalid), .pix_ready(pready), .pix_is_index(pidx_f),
        .pix_index(pidx), .pix_rgb(prgb), .line_cols(cols), .line_bytes(lbytes)
    );

    fb_word_unpacker #(.EXTENDED(1'b1)) uut_ext (
        .clk(clk), .rst_n(rst_n), .depth_code(depth), .order_big_bytes(bbyte),
        .order_big_pixels(bpix), .swap_rb(swp), .fmt_sel(fsel),
        .word_valid(wvalid), .word_data(wdata), .word_ready(x_wready),
        .pix_valid(x_pvalid), .pix_ready(pready), .pix_is_index(x_pidx_f),
        .pix_index(x_pidx), .pix_rgb(x_prgb), .line_cols(cols), .line_bytes(x_lbytes)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lg_of(input logic [2:0] d);
        return (d < 3'd4) ? int'(d) : (d == 3'd5) ? 5 : 4;
    endfunction

    // Expected {is_index, index, rgb} for pixel i, built from the requirements
    function automatic logic [32:0] model(input logic [31:0] w, input int i, input logic [2:0] d,
                                          input bit bb, input bit bp, input bit sw,
                                          input logic [1:0] fs, input bit ext);
        int lg = lg_of(d);
        int pw = 1 << lg;
        int msk = bb ? 32 - pw : (bp && pw < 8) ? 8 - pw : 0;
        int off = (i * pw) ^ msk;
        logic [31:0] f = w >> off;
        logic [7:0] a, b, c, r, bl;
        int kind;
        bit s = sw;
        if (d < 3'd4) return {1'b1, 8'(f & ((1 << pw) - 1)), 24'h0};
        if (d == 3'd5) kind = 3;
        else if (ext) kind = (d == 3'd4) ? 0 : (d == 3'd6) ? 1 : 2;
        else begin
            kind = (fs == 2'd1) ? 0 : 1;
            if (fs == 2'd3) s = 1'b1;
        end
        case (kind)
            0: begin a = {f[4:0], 3'b0}; b = {f[9:5], 3'b0};  c = {f[14:10], 3'b0}; end
            1: begin a = {f[4:0], 3'b0}; b = {f[10:5], 2'b0}; c = {f[15:11], 3'b0}; end
            2: begin a = {f[3:0], 4'b0}; b = {f[7:4], 4'b0};  c = {f[11:8], 4'b0};  end
            default: begin a = f[7:0]; b = f[15:8]; c = f[23:16]; end
        endcase
        r  = s ? c : a;
        bl = s ? a : c;
        return {1'b0, 8'h00, r, b, bl};
    endfunction

    // Push one word and check every pixel of both variants; optional stall or control change
    task automatic run_word(input logic [31:0] w, input string req, input bit stall, input bit disturb);
        logic [2:0] d = depth;
        bit bb = bbyte, bp = bpix, sw = swp;
        logic [1:0] fs = fsel;
        int n = 32 >> lg_of(d);
        logic [32:0] e0, e1;
        @(negedge clk);
        wvalid = 1'b1; wdata = w; pready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wvalid = 1'b0; wdata = 32'hDEAD_BEEF;
        for (int i = 0; i < n; i++) begin
            e0 = model(w, i, d, bb, bp, sw, fs, 1'b0);
            e1 = model(w, i, d, bb, bp, sw, fs, 1'b1);
            chk(pvalid && {pidx_f, pidx, prgb} == e0, req, {pvalid, pidx_f, pidx, prgb}, {1'b1, e0});
            chk(x_pvalid && {x_pidx_f, x_pidx, x_prgb} == e1, {req, " ext"}, {x_pvalid, x_pidx_f, x_pidx, x_prgb}, {1'b1, e1});
            if (i < n - 1) chk(!wready && !x_wready, "R2 busy", {wready, x_wready}, 0);
            if (disturb && i == 0) begin
                // R12: scramble every control while the word is held
                depth = ~d; bbyte = ~bb; bpix = ~bp; swp = ~sw; fsel = ~fs;
            end
            if (stall && i == 1) begin
                pready = 1'b0;
                repeat (3) begin
                    @(posedge clk); @(negedge clk);
                    chk(pvalid && {pidx_f, pidx, prgb} == e0 && !wready, "R2 stall",
                        {pvalid, pidx_f, pidx, prgb}, {1'b1, e0});
                end
                pready = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
        end
        chk(wready && !pvalid && x_wready && !x_pvalid, "R2 word done", {wready, pvalid}, 2'b10);
        depth = d; bbyte = bb; bpix = bp; swp = sw; fsel = fs;
    endtask

    task automatic set_cfg(input logic [2:0] d, input bit bb, input bit bp, input bit sw, input logic [1:0] fs);
        @(negedge clk);
        depth = d; bbyte = bb; bpix = bp; swp = sw; fsel = fs;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!pvalid && wready && !x_pvalid && x_wready, "R1 reset", {pvalid, wready}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pvalid && wready, "R1 after reset", {pvalid, wready}, 2'b01);
    endtask

    task automatic t_index_le();
        for (int d = 0; d < 4; d++) begin
            set_cfg(3'(d), 0, 0, 0, 0);
            run_word(32'hA5C3_1E96, "R3 R4 indexed little-endian", 0, 0);
        end
    endtask

    task automatic t_big_bytes();
        for (int d = 0; d < 6; d++) begin
            set_cfg(3'(d), 1, d[0], 0, 1);
            run_word(32'h1234_9ABC ^ 32'(d * 32'h0101_0707), "R5 big-endian bytes", 0, 0);
        end
    endtask

    task automatic t_big_pixels();
        for (int d = 0; d < 6; d++) begin
            set_cfg(3'(d), 0, 1, 0, 1);
            run_word(32'h6B2D_F04C, "R6 big pixels in little bytes", 0, 0);
        end
    endtask

    task automatic t_5551();
        set_cfg(3'd4, 0, 0, 0, 2'd1);
        run_word(32'hFC1F_83E0, "R7 5551 channels", 0, 0);
        run_word(32'h7FFF_8001, "R7 5551 top bit ignored", 0, 0);
    endtask

    task automatic t_888();
        set_cfg(3'd5, 0, 0, 0, 0);
        run_word(32'hFF12_3456, "R8 32bpp channels", 0, 0);
        set_cfg(3'd5, 0, 0, 1, 0);
        run_word(32'h00AB_CDEF, "R9 32bpp swapped", 0, 0);
    endtask

    task automatic t_mux();
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                set_cfg(3'd4, 0, 0, s[0], 2'(m));
                run_word(32'hF81F_07E0 ^ 32'(m * 32'h1111), "R10 R9 16-bit selector", 0, 0);
            end
        end
    endtask

    task automatic t_codes67();
        for (int d = 6; d < 8; d++) begin
            for (int m = 0; m < 4; m += 3) begin
                set_cfg(3'(d), 0, 0, 1'(m == 0), 2'(m));
                run_word(32'h0F3A_C5E7, "R11 codes 6 and 7", 0, 0);
            end
        end
    endtask

    task automatic t_stall();
        set_cfg(3'd2, 0, 0, 0, 0);
        run_word(32'h8765_4321, "R2 stall word", 1, 0);
    endtask

    task automatic t_latch();
        set_cfg(3'd2, 0, 0, 0, 0);
        run_word(32'h2468_ACE1, "R12 controls captured", 0, 1);
        set_cfg(3'd4, 1, 0, 0, 2'd1);
        run_word(32'h1357_9BDF, "R12 controls captured 16-bit", 0, 1);
    endtask

    task automatic t_lines();
        int exp;
        for (int d = 0; d < 8; d++) begin
            @(negedge clk);
            depth = 3'(d); cols = 12'd640;
            #1;
            exp = (d == 0) ? 80 : (d == 1) ? 160 : (d == 2) ? 320 : (d == 3) ? 640 : (d == 5) ? 2560 : 1280;
            chk(int'(lbytes) == exp && int'(x_lbytes) == exp, "R13 line bytes", lbytes, exp);
        end
        @(negedge clk);
        depth = 3'd0; cols = 12'd13;
        #1;
        chk(lbytes == 14'd1, "R13 line bytes floor", lbytes, 1);
        depth = 3'd5; cols = 12'd4095;
        #1;
        chk(lbytes == 14'd16380, "R13 line bytes max", lbytes, 16380);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_index_le();
        t_big_bytes();
        t_big_pixels();
        t_5551();
        t_888();
        t_mux();
        t_codes67();
        t_stall();
        t_latch();
        t_lines();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule